// File: doc/BRIEF.md
# Speculative and Committed Register Alias Table

This block maps logical register numbers to physical register numbers for an out-of-order core. It holds two full copies of the map. The speculative copy changes as instructions are renamed and feeds every rename-time lookup. The committed copy changes only as instructions retire. Rename lanes look up their source operands and the current mapping of their destination. That destination mapping is the physical register the instruction will later release.

Recovery takes two forms. A walk replays squashed instructions through the commit lanes, youngest first. Each walked lane writes that instruction's previous physical destination back into the speculative copy. A redirect reloads the whole speculative copy from the committed copy in a single cycle. One parameter selects the number of source lookups per lane: two for an integer table and three for a floating-point table. A second parameter pins logical register 0 to physical register 0.

Top module: `renameMap`

## Requirements
- R1: After reset, both copies map every logical register i to physical register i.
- R2: There are RenLanes*(SrcCnt+1) read ports, numbered lane*(SrcCnt+1)+k. Slots k < SrcCnt serve sources, and slot SrcCnt returns the destination's current mapping. Read port p returns the speculative entry at rdAddr[p*LW +: LW] combinationally. A write becomes visible only after the next rising clock edge.
- R3: While walk is low and redirect is low, a rename lane with renWen set loads renData into the speculative entry at renAddr on the next edge. Rename writes are ignored while walk is high. Ports at or above RenLanes never write outside a walk.
- R4: While walk is high, each commit lane with cmtValid set writes cmtOldPdest into the speculative entry at cmtDest. This applies to every commit lane, including those beyond the rename width.
- R5: While walk is low, each commit lane with cmtValid set writes cmtPdest into the committed entry at cmtDest. While walk is high, the committed copy does not change.
- R6: With ZeroLocked set, logical register 0 stays mapped to physical register 0 in both copies, and any write aimed at it is dropped.
- R7: When redirect is high, the speculative copy becomes equal to the committed copy. That image includes any commit writes of the same cycle. The restore overrides every speculative write of that cycle.
- R8: When several lanes write the same entry of one copy in the same cycle, the highest-numbered lane's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| redirect | input | 1 | Reload the speculative copy from the committed copy |
| walk | input | 1 | Commit lanes carry walk writes instead of retirements |
| renWen | input | RenLanes | Per-lane rename write enable |
| renAddr | input | RenLanes*LW | Per-lane logical destination |
| renData | input | RenLanes*PW | Per-lane newly allocated physical register |
| cmtValid | input | CmtLanes | Commit or walk lane carries an instruction with a destination |
| cmtDest | input | CmtLanes*LW | Logical destination per commit lane |
| cmtPdest | input | CmtLanes*PW | New physical destination (retirement) |
| cmtOldPdest | input | CmtLanes*PW | Previous physical destination (walk) |
| rdAddr | input | NumRead*LW | Logical address per read port |
| rdData | output | NumRead*PW | Speculative mapping per read port |

## Verification
The case that most needs coverage is a redirect arriving in the same cycle as retirements and a rename write. The restore must take in the committed entries written that very cycle, and the rename write must vanish. The bench sets all three inputs together. It then sweeps every speculative entry through the read ports and compares each one against a reference map that applies the commit first and then copies it. A second overlap, walk together with rename enables, is judged the same way. The walk values must appear, the rename values must not, and a later redirect must show that the committed copy stayed unchanged.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  typedef struct packed {
    logic restore;
    logic walkPhase;
  } rmapStrobe_t;
endpackage

// File: rtl/rmapCtrl.sv
module rmapCtrl
  import rmap_pkg::*;
#(
  parameter int RenLanes   = 4,
  parameter int CmtLanes   = 6,
  parameter int LW         = 5,
  parameter bit ZeroLocked = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   redirect,
  input  logic                   walk,
  input  logic [RenLanes-1:0]    renWen,
  input  logic [RenLanes*LW-1:0] renAddr,
  input  logic [CmtLanes-1:0]    cmtValid,
  input  logic [CmtLanes*LW-1:0] cmtDest,
  output rmapStrobe_t            strb,
  output logic [CmtLanes-1:0]    specWen,
  output logic [CmtLanes-1:0]    archWen
);
  assign strb.restore   = redirect;
  assign strb.walkPhase = walk;

  for (genvar i = 0; i < CmtLanes; i++) begin : gLane
    logic cmtZero;
    assign cmtZero    = ZeroLocked && (cmtDest[i*LW +: LW] == '0);
    assign archWen[i] = !walk && cmtValid[i] && !cmtZero;
    if (i < RenLanes) begin : gRen
      logic renZero;
      assign renZero    = ZeroLocked && (renAddr[i*LW +: LW] == '0);
      assign specWen[i] = !redirect &&
                          (walk ? (cmtValid[i] && !cmtZero) : (renWen[i] && !renZero));
    end else begin : gWalkOnly
      assign specWen[i] = !redirect && walk && cmtValid[i] && !cmtZero;
      p_extra_port_walk_only_r3: assert property (@(posedge clk) disable iff (!rstN)
        !walk |-> !specWen[i]);
    end
    p_walk_lane_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
      (walk && !cmtValid[i]) |-> !specWen[i]);
  end

  p_walk_freezes_arch_r5: assert property (@(posedge clk) disable iff (!rstN)
    walk |-> (archWen == '0));
endmodule

// File: rtl/rmapData.sv
module rmapData
  import rmap_pkg::*;
#(
  parameter int LogRegs    = 32,
  parameter int PhysRegs   = 64,
  parameter int RenLanes   = 4,
  parameter int CmtLanes   = 6,
  parameter int NumRead    = 12,
  parameter bit ZeroLocked = 1'b1,
  localparam int LW = $clog2(LogRegs),
  localparam int PW = $clog2(PhysRegs)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rmapStrobe_t            strb,
  input  logic [CmtLanes-1:0]    specWen,
  input  logic [CmtLanes-1:0]    archWen,
  input  logic [RenLanes*LW-1:0] renAddr,
  input  logic [RenLanes*PW-1:0] renData,
  input  logic [CmtLanes*LW-1:0] cmtDest,
  input  logic [CmtLanes*PW-1:0] cmtPdest,
  input  logic [CmtLanes*PW-1:0] cmtOldPdest,
  input  logic [NumRead*LW-1:0]  rdAddr,
  output logic [NumRead*PW-1:0]  rdData
);
  logic [PW-1:0] specTab [LogRegs];
  logic [PW-1:0] archTab [LogRegs];
  logic [PW-1:0] specNxt [LogRegs];
  logic [PW-1:0] archNxt [LogRegs];

  logic [LW-1:0] wAddr [CmtLanes];
  logic [PW-1:0] wData [CmtLanes];
  logic [LW-1:0] aAddr [CmtLanes];
  logic [PW-1:0] aData [CmtLanes];

  // Shared speculative ports: walk lanes take over, extra ports idle otherwise
  for (genvar i = 0; i < CmtLanes; i++) begin : gPort
    assign aAddr[i] = cmtDest[i*LW +: LW];
    assign aData[i] = cmtPdest[i*PW +: PW];
    if (i < RenLanes) begin : gShared
      assign wAddr[i] = strb.walkPhase ? cmtDest[i*LW +: LW]     : renAddr[i*LW +: LW];
      assign wData[i] = strb.walkPhase ? cmtOldPdest[i*PW +: PW] : renData[i*PW +: PW];
    end else begin : gWalk
      assign wAddr[i] = cmtDest[i*LW +: LW];
      assign wData[i] = cmtOldPdest[i*PW +: PW];
    end
  end

  // Later lanes overwrite earlier ones: highest lane wins
  always_comb begin
    archNxt = archTab;
    for (int i = 0; i < CmtLanes; i++)
      if (archWen[i]) archNxt[aAddr[i]] = aData[i];
  end

  always_comb begin
    if (strb.restore) begin
      specNxt = archNxt;
    end else begin
      specNxt = specTab;
      for (int i = 0; i < CmtLanes; i++)
        if (specWen[i]) specNxt[wAddr[i]] = wData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < LogRegs; e++) begin
        specTab[e] <= PW'(e);
        archTab[e] <= PW'(e);
      end
    end else begin
      specTab <= specNxt;
      archTab <= archNxt;
    end
  end

  for (genvar p = 0; p < NumRead; p++) begin : gRead
    assign rdData[p*PW +: PW] = specTab[rdAddr[p*LW +: LW]];
  end

  logic tabsMatch;
  always_comb begin
    tabsMatch = 1'b1;
    for (int e = 0; e < LogRegs; e++)
      if (specTab[e] != archTab[e]) tabsMatch = 1'b0;
  end

  p_restore_equal_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.restore |=> tabsMatch);

  if (ZeroLocked) begin : gZeroChk
    p_zero_pinned_r6: assert property (@(posedge clk) disable iff (!rstN)
      (specTab[0] == '0) && (archTab[0] == '0));
  end
endmodule

// File: rtl/renameMap.sv
module renameMap
  import rmap_pkg::*;
#(
  parameter int LogRegs    = 32,
  parameter int PhysRegs   = 64,
  parameter int RenLanes   = 4,
  parameter int CmtLanes   = 6,
  parameter int SrcCnt     = 2,
  parameter bit ZeroLocked = 1'b1,
  localparam int LW      = $clog2(LogRegs),
  localparam int PW      = $clog2(PhysRegs),
  localparam int NumRead = RenLanes * (SrcCnt + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   redirect,
  input  logic                   walk,
  input  logic [RenLanes-1:0]    renWen,
  input  logic [RenLanes*LW-1:0] renAddr,
  input  logic [RenLanes*PW-1:0] renData,
  input  logic [CmtLanes-1:0]    cmtValid,
  input  logic [CmtLanes*LW-1:0] cmtDest,
  input  logic [CmtLanes*PW-1:0] cmtPdest,
  input  logic [CmtLanes*PW-1:0] cmtOldPdest,
  input  logic [NumRead*LW-1:0]  rdAddr,
  output logic [NumRead*PW-1:0]  rdData
);
  initial begin
    assert (PhysRegs >= LogRegs) else $error("identity image needs PhysRegs >= LogRegs");
    assert (CmtLanes >= RenLanes) else $error("commit lanes must cover rename lanes");
  end

  rmapStrobe_t        strb;
  logic [CmtLanes-1:0] specWen;
  logic [CmtLanes-1:0] archWen;

  rmapCtrl #(
    .RenLanes(RenLanes), .CmtLanes(CmtLanes), .LW(LW), .ZeroLocked(ZeroLocked)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .redirect(redirect), .walk(walk),
    .renWen(renWen), .renAddr(renAddr), .cmtValid(cmtValid), .cmtDest(cmtDest),
    .strb(strb), .specWen(specWen), .archWen(archWen)
  );

  rmapData #(
    .LogRegs(LogRegs), .PhysRegs(PhysRegs), .RenLanes(RenLanes),
    .CmtLanes(CmtLanes), .NumRead(NumRead), .ZeroLocked(ZeroLocked)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .specWen(specWen), .archWen(archWen),
    .renAddr(renAddr), .renData(renData), .cmtDest(cmtDest), .cmtPdest(cmtPdest),
    .cmtOldPdest(cmtOldPdest), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/sim_renameMap.sv
module sim_renameMap;
  localparam int NL = 32, RL = 4, CL = 6, LW = 5, PW = 6, NR = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic redirect, walk;
  logic [RL-1:0]    renWen;
  logic [RL*LW-1:0] renAddr;
  logic [RL*PW-1:0] renData;
  logic [CL-1:0]    cmtValid;
  logic [CL*LW-1:0] cmtDest;
  logic [CL*PW-1:0] cmtPdest, cmtOldPdest;
  logic [NR*LW-1:0] rdAddr;
  logic [NR*PW-1:0] rdData;

  int expS [NL];
  int expA [NL];
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  renameMap u0 (
    .clk(clk), .rstN(rstN), .redirect(redirect), .walk(walk),
    .renWen(renWen), .renAddr(renAddr), .renData(renData),
    .cmtValid(cmtValid), .cmtDest(cmtDest), .cmtPdest(cmtPdest),
    .cmtOldPdest(cmtOldPdest), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    redirect = 0; walk = 0; renWen = '0; renAddr = '0; renData = '0;
    cmtValid = '0; cmtDest = '0; cmtPdest = '0; cmtOldPdest = '0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic ren(int l, int a, int d);
    renWen[l] = 1'b1; renAddr[l*LW +: LW] = LW'(a); renData[l*PW +: PW] = PW'(d);
  endtask

  task automatic cmt(int l, int a, int pd, int od);
    cmtValid[l] = 1'b1; cmtDest[l*LW +: LW] = LW'(a);
    cmtPdest[l*PW +: PW] = PW'(pd); cmtOldPdest[l*PW +: PW] = PW'(od);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < NL; a++) begin
      int p = a % NR;
      rdAddr[p*LW +: LW] = LW'(a);
      #1;
      chk($sformatf("%s entry %0d", tag, a), int'(rdData[p*PW +: PW]), expS[a]);
    end
  endtask

  task automatic restoreAll();
    redirect = 1'b1; step();
    for (int a = 0; a < NL; a++) expS[a] = expA[a];
  endtask

  task automatic tReset();
    for (int a = 0; a < NL; a++) begin expS[a] = a; expA[a] = a; end
    sweep("R1 spec reset");
    restoreAll();
    sweep("R1 arch reset via restore");
  endtask

  task automatic tReadPorts();
    for (int p = 0; p < NR; p++) rdAddr[p*LW +: LW] = LW'((p * 5 + 3) % NL);
    #1;
    for (int p = 0; p < NR; p++)
      chk($sformatf("R2 port %0d", p), int'(rdData[p*PW +: PW]), expS[(p * 5 + 3) % NL]);
    ren(0, 7, 40);
    rdAddr[0 +: LW] = LW'(7);
    #1;
    chk("R2 read before edge", int'(rdData[0 +: PW]), 7);
    step(); expS[7] = 40;
    #1;
    chk("R2 read after edge", int'(rdData[0 +: PW]), 40);
  endtask

  task automatic tRename();
    ren(0, 1, 41); ren(1, 2, 42); ren(2, 3, 43); ren(3, 4, 44);
    step();
    expS[1] = 41; expS[2] = 42; expS[3] = 43; expS[4] = 44;
    sweep("R3 rename lanes");
  endtask

  task automatic tConflict();
    ren(0, 10, 49); ren(1, 10, 50); ren(3, 10, 51);
    step(); expS[10] = 51;
    sweep("R8 rename conflict");
    walk = 1'b1; cmt(2, 11, 0, 20); cmt(5, 11, 0, 21);
    step(); expS[11] = 21;
    sweep("R8 walk conflict");
  endtask

  task automatic tZero();
    ren(2, 0, 33);
    step();
    sweep("R6 rename to zero");
    cmt(1, 0, 34, 0);
    step();
    restoreAll();
    sweep("R6 commit to zero");
  endtask

  task automatic tCommit();
    for (int l = 0; l < CL; l++) cmt(l, 12 + l, 50 + l, 0);
    step();
    for (int l = 0; l < CL; l++) expA[12 + l] = 50 + l;
    sweep("R5 commit leaves spec");
    restoreAll();
    sweep("R5 R7 restore after commit");
  endtask

  task automatic tWalk();
    walk = 1'b1;
    ren(0, 20, 60); ren(1, 21, 61); ren(2, 22, 62); ren(3, 23, 63);
    cmt(0, 26, 9, 32); cmt(4, 24, 9, 30); cmt(5, 25, 9, 31);
    step();
    expS[26] = 32; expS[24] = 30; expS[25] = 31;
    sweep("R4 walk writes, R3 rename ignored");
    restoreAll();
    sweep("R5 arch unchanged by walk");
  endtask

  task automatic tRedirectOverlap();
    ren(0, 5, 45);
    cmt(1, 6, 46, 0);
    redirect = 1'b1;
    step();
    expA[6] = 46;
    for (int a = 0; a < NL; a++) expS[a] = expA[a];
    sweep("R7 redirect with commit and rename");
  endtask

  initial begin
    idle(); rdAddr = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tReadPorts();
    tRename();
    tConflict();
    tZero();
    tCommit();
    tWalk();
    tRedirectOverlap();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule